// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block collects level-sensitive requests from up to 32 sources and drives a single interrupt request line to a processor core. Software assigns sources to a set of numbered vector slots. Each slot has a control word that holds an enable flag and a source number, and an address word that holds the entry point of the handler for that source. A lower slot index means a higher priority.

When the core takes the interrupt, it reads the shared vector register and gets the handler address of the winning slot. If the only pending sources have no slot, it gets a programmable fallback address instead. The read latches the winner. From then on, that slot, every slot of lower priority and the fallback stay hidden until software writes the vector register to acknowledge. While a winner is held, a slot of higher priority can still interrupt.

All state is reached over a simple word-addressed register port. Writes take effect at the clock edge. Read data appears on `rdata_o` one cycle after the request.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, `irq_o` is low, no winner is held, and all registers read zero: the source mask, the fallback address, and every slot control and address word.
- R2: The source mask at word 0x00 has one bit per source, with bit k for source k. A source whose mask bit is 0 does not raise `irq_o` and does not change the vector read.
- R3: Slot n has a control word at 0x40+n and an address word at 0x80+n. In the control word, bit 5 enables the slot and bits 4:0 select the source. For example, 0x20|17 means enabled for source 17. Both words read back what was written.
- R4: `irq_o` is high whenever a masked-in source is active and served by an enabled, visible slot. It is low when no source is active.
- R5: A read of the vector register at word 0x02 returns the address word of the lowest-index enabled slot whose source is active and masked in.
- R6: A masked-in active source that no enabled slot serves raises `irq_o` and makes the vector read return the fallback address at word 0x03. Any pending slot takes precedence over the fallback.
- R7: A vector read that finds a pending request holds that winner. Until the acknowledge, the winning slot, all higher-index slots and the fallback are hidden from `irq_o` and from the vector read. Lower-index slots still raise `irq_o` and can replace the held winner.
- R8: Any write to the vector register acknowledges and releases the hold. The next read reflects the current requests.
- R9: A vector read with no visible request returns the fallback address and leaves the hold unchanged.
- R10: Word 0x01 reads the active sources ANDed with the source mask.
- R11: Clearing a slot's enable bit removes that slot from arbitration. Its source then falls through to the fallback address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level-sensitive source requests, active high |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Sixteen slots are mapped to sources (5n+3) mod 32, which leaves half the sources without a slot. A sweep that raises each of the 32 sources alone therefore separates slot lookup from fallback, and checks hiding and release after every read. A sweep over all 120 pairs of mapped slots checks that the lower index always wins, whatever the source numbers are. Directed sequences cover the following cases:
- a nested hold, where a lower-priority request arrives and stays hidden while a higher-priority one breaks through;
- a slot competing with an unmapped source;
- an empty read;
- a source masked off;
- a slot disabled after programming.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] OFS_SRC_EN  = 8'h00;
  localparam logic [REG_AW-1:0] OFS_STATUS  = 8'h01;
  localparam logic [REG_AW-1:0] OFS_VECTOR  = 8'h02;
  localparam logic [REG_AW-1:0] OFS_DEFAULT = 8'h03;
  localparam logic [1:0]        PAGE_CTRL   = 2'b01;
  localparam logic [1:0]        PAGE_ADDR   = 2'b10;
endpackage

// File: rtl/irqv_slot_bank.sv
module irqv_slot_bank #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned DW       = 32,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC),
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              ctrl_we_i,
  input  logic                              addr_we_i,
  input  logic [SLOT_W-1:0]                 sel_i,
  input  logic [DW-1:0]                     wdata_i,
  input  logic [NUM_SRC-1:0]                src_act_i,
  output logic [NUM_SLOT-1:0]               slot_en_o,
  output logic [NUM_SLOT-1:0][SRC_W-1:0]    slot_src_o,
  output logic [NUM_SLOT-1:0][DW-1:0]       slot_addr_o,
  output logic [NUM_SLOT-1:0]               hit_o,
  output logic [NUM_SRC-1:0]                mapped_o
);
  logic [NUM_SLOT-1:0]            en_q;
  logic [NUM_SLOT-1:0][SRC_W-1:0] src_q;
  logic [NUM_SLOT-1:0][DW-1:0]    addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      src_q  <= '0;
      addr_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q[sel_i]  <= wdata_i[SRC_W];
        src_q[sel_i] <= wdata_i[SRC_W-1:0];
      end
      if (addr_we_i) addr_q[sel_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_hit
    assign hit_o[g] = en_q[g] & src_act_i[src_q[g]];
  end

  // sources served by at least one enabled slot
  always_comb begin
    mapped_o = '0;
    for (int g = 0; g < NUM_SLOT; g++) begin
      if (en_q[g]) mapped_o[src_q[g]] = 1'b1;
    end
  end

  assign slot_en_o   = en_q;
  assign slot_src_o  = src_q;
  assign slot_addr_o = addr_q;
endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // scan downward so the lowest index is assigned last and wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  parameter int unsigned DW       = 32,
  localparam int unsigned SRC_W   = $clog2(NUM_SRC),
  localparam int unsigned SLOT_W  = $clog2(NUM_SLOT),
  localparam int unsigned LVL_W   = $clog2(NUM_SLOT + 2)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [7:0]         addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic               irq_o
);
  import irqv_pkg::*;

  // hold level: slots with index below it stay visible; NO_HOLD shows all plus fallback
  localparam logic [LVL_W-1:0] NO_HOLD  = LVL_W'(NUM_SLOT + 1);
  localparam logic [LVL_W-1:0] DFLT_LVL = LVL_W'(NUM_SLOT);

  logic [NUM_SRC-1:0]             src_en_q;
  logic [DW-1:0]                  dflt_q;
  logic [LVL_W-1:0]               hold_q;
  logic [NUM_SRC-1:0]             src_act, mapped;
  logic [NUM_SLOT-1:0]            slot_en, hit, vis_mask, slot_vis;
  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src;
  logic [NUM_SLOT-1:0][DW-1:0]    slot_addr;
  logic                           found, dflt_vis, in_range;
  logic                           rd, wr, vec_rd, vec_wr;
  logic [SLOT_W-1:0]              win_idx, sel;
  logic [LVL_W-1:0]               win_lvl;
  logic [DW-1:0]                  win_addr, rdata_d;

  assign rd       = req_i & ~we_i;
  assign wr       = req_i & we_i;
  assign vec_rd   = rd & (addr_i == OFS_VECTOR);
  assign vec_wr   = wr & (addr_i == OFS_VECTOR);
  assign sel      = addr_i[SLOT_W-1:0];
  assign in_range = int'(addr_i[5:0]) < NUM_SLOT;
  assign src_act  = src_i & src_en_q;

  irqv_slot_bank #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DW(DW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (wr & in_range & (addr_i[7:6] == PAGE_CTRL)),
    .addr_we_i  (wr & in_range & (addr_i[7:6] == PAGE_ADDR)),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .src_act_i  (src_act),
    .slot_en_o  (slot_en),
    .slot_src_o (slot_src),
    .slot_addr_o(slot_addr),
    .hit_o      (hit),
    .mapped_o   (mapped)
  );

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_vis
    assign vis_mask[g] = LVL_W'(g) < hold_q;
  end
  assign slot_vis = hit & vis_mask;

  irqv_prio_pick #(.N(NUM_SLOT)) u_pick (
    .req_i  (slot_vis),
    .found_o(found),
    .idx_o  (win_idx)
  );

  assign dflt_vis = (|(src_act & ~mapped)) & (hold_q == NO_HOLD);
  assign irq_o    = found | dflt_vis;
  assign win_lvl  = found ? LVL_W'(win_idx) : DFLT_LVL;
  assign win_addr = found ? slot_addr[win_idx] : dflt_q;

  always_comb begin
    rdata_d = '0;
    if (addr_i == OFS_SRC_EN)                        rdata_d = DW'(src_en_q);
    else if (addr_i == OFS_STATUS)                   rdata_d = DW'(src_act);
    else if (addr_i == OFS_VECTOR)                   rdata_d = win_addr;
    else if (addr_i == OFS_DEFAULT)                  rdata_d = dflt_q;
    else if (addr_i[7:6] == PAGE_CTRL && in_range)   rdata_d = DW'({slot_en[sel], slot_src[sel]});
    else if (addr_i[7:6] == PAGE_ADDR && in_range)   rdata_d = slot_addr[sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_en_q <= '0;
      dflt_q   <= '0;
      hold_q   <= NO_HOLD;
      rdata_o  <= '0;
    end else begin
      if (wr && addr_i == OFS_SRC_EN)  src_en_q <= wdata_i[NUM_SRC-1:0];
      if (wr && addr_i == OFS_DEFAULT) dflt_q   <= wdata_i;
      if (vec_wr)                      hold_q   <= NO_HOLD;
      else if (vec_rd && irq_o)        hold_q   <= win_lvl;
      if (rd)                          rdata_o  <= rdata_d;
    end
  end
endmodule

// File: rtl/irqv_ctrl_chk.sv
module irqv_ctrl_chk #(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned NUM_SLOT = 16,
  localparam int unsigned LVL_W   = $clog2(NUM_SLOT + 2)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               irq_o,
  input logic               vec_rd_i,
  input logic               vec_wr_i,
  input logic [LVL_W-1:0]   hold_i
);
  localparam logic [LVL_W-1:0] NO_HOLD = LVL_W'(NUM_SLOT + 1);

  assert_idle_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> !irq_o);

  assert_ack_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_wr_i |=> (hold_i == NO_HOLD));

  assert_read_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && irq_o) |=> (hold_i != NO_HOLD));

  assert_empty_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && !irq_o) |=> $stable(hold_i));

  assert_hold_steady_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vec_wr_i && !vec_rd_i) |=> $stable(hold_i));

  assert_hold_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i <= NO_HOLD);
endmodule

bind irqv_ctrl irqv_ctrl_chk #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .irq_o   (irq_o),
  .vec_rd_i(vec_rd),
  .vec_wr_i(vec_wr),
  .hold_i  (hold_q)
);

// File: tb/irqv_ctrl_test.sv
`timescale 1ns/1ps
module irqv_ctrl_test;
  localparam logic [31:0] DFLT = 32'h0000_F00C;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          n_tests = 0, n_fail = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  irqv_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int src_of(int n);
    return (n * 5 + 3) % 32;
  endfunction

  function automatic int slot_for(int s);
    for (int n = 0; n < 16; n++) if (src_of(n) == s) return n;
    return -1;
  endfunction

  function automatic logic [31:0] hand(int n);
    return 32'h1000_0000 + 32'(n) * 32'h10;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata;
  endtask

  task automatic set_src(logic [31:0] v);
    @(negedge clk); src = v; #1;
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1 irq after reset", 32'(irq), 0);
    rd(8'h00, got); check("R1 mask reset", got, 0);
    rd(8'h03, got); check("R1 fallback reset", got, 0);
    rd(8'h45, got); check("R1 ctrl reset", got, 0);
    rd(8'h8F, got); check("R1 addr reset", got, 0);
    rd(8'h02, got); check("R1 vector reset", got, 0);

    // program slots
    wr(8'h03, DFLT);
    for (int n = 0; n < 16; n++) begin
      wr(8'h40 + 8'(n), 32'h20 | 32'(src_of(n)));
      wr(8'h80 + 8'(n), hand(n));
    end
    for (int n = 0; n < 16; n++) begin
      rd(8'h40 + 8'(n), got); check("R3 ctrl readback", got, 32'h20 | 32'(src_of(n)));
      rd(8'h80 + 8'(n), got); check("R3 addr readback", got, hand(n));
    end

    // all sources masked off
    set_src(32'hFFFF_FFFF);
    check("R2 masked irq", 32'(irq), 0);
    rd(8'h01, got); check("R10 masked status", got, 0);
    set_src(0);
    wr(8'h00, 32'hFFFF_FFFF);

    // single-source sweep
    for (int s = 0; s < 32; s++) begin
      int k;
      k = slot_for(s);
      set_src(32'(1) << s);
      check(k >= 0 ? "R4 irq single" : "R6 irq unmapped", 32'(irq), 1);
      rd(8'h01, got); check("R10 status", got, 32'(1) << s);
      rd(8'h02, got);
      check(k >= 0 ? "R5 vector single" : "R6 vector fallback", got, k >= 0 ? hand(k) : DFLT);
      check("R7 hidden after read", 32'(irq), 0);
      wr(8'h02, 0);
      check("R8 visible after ack", 32'(irq), 1);
      set_src(0);
    end

    // pairwise priority sweep
    for (int i = 0; i < 16; i++) begin
      for (int j = i + 1; j < 16; j++) begin
        set_src((32'(1) << src_of(i)) | (32'(1) << src_of(j)));
        rd(8'h02, got); check("R5 pair priority", got, hand(i));
        wr(8'h02, 0);
      end
    end
    set_src(0);

    // slot beats fallback
    for (int s = 0; s < 32; s++) begin
      if (slot_for(s) < 0) begin
        set_src((32'(1) << s) | (32'(1) << src_of(15)));
        rd(8'h02, got); check("R6 slot over fallback", got, hand(15));
        check("R7 fallback hidden", 32'(irq), 0);
        wr(8'h02, 0);
        rd(8'h02, got); check("R8 fallback after ack", got, hand(15));
        wr(8'h02, 0);
        break;
      end
    end
    set_src(0);

    // nested hold
    set_src(32'(1) << src_of(5));
    rd(8'h02, got); check("R5 hold first", got, hand(5));
    set_src(src | (32'(1) << src_of(9)));
    check("R7 lower priority hidden", 32'(irq), 0);
    rd(8'h02, got); check("R7 hidden vector", got, DFLT);
    set_src(src | (32'(1) << src_of(2)));
    check("R7 higher priority breaks through", 32'(irq), 1);
    rd(8'h02, got); check("R7 nested winner", got, hand(2));
    check("R7 nested hides", 32'(irq), 0);
    wr(8'h02, 0);
    check("R8 release irq", 32'(irq), 1);
    rd(8'h02, got); check("R8 release vector", got, hand(2));
    wr(8'h02, 0);
    set_src(0);

    // empty read
    rd(8'h02, got); check("R9 empty vector", got, DFLT);
    set_src(32'(1) << src_of(3));
    check("R9 no hold after empty read", 32'(irq), 1);
    set_src(0);

    // mask one source
    wr(8'h00, ~(32'(1) << src_of(0)));
    set_src(32'(1) << src_of(0));
    check("R2 masked source irq", 32'(irq), 0);
    rd(8'h02, got); check("R2 masked source vector", got, DFLT);
    set_src(0);
    wr(8'h00, 32'hFFFF_FFFF);

    // disable slot 4
    wr(8'h44, 32'(src_of(4)));
    set_src(32'(1) << src_of(4));
    check("R11 disabled slot irq", 32'(irq), 1);
    rd(8'h02, got); check("R11 disabled slot vector", got, DFLT);
    wr(8'h02, 0);
    set_src(0);
    check("R4 idle irq", 32'(irq), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule